// File: doc/BRIEF.md
# CSR Instruction Execution Unit

This block carries out the six control-and-status register access instructions of a 32-bit RISC-V core against a small local bank of 32-bit registers. Each cycle it may be handed one instruction word, a qualifying valid flag, and the value already read from the integer register named by the source field. It decodes the word and picks the register from the 12-bit address field. It then forms the new register value by plain write, bit set or bit clear, using either the source register value or the 5-bit immediate. The value the register held before the instruction is handed back with a valid flag, so the pipeline can write it to the destination register.

The operand fields decide what side effects an access has. A plain write whose destination is x0 performs no read and raises no valid flag. A set or clear whose source field is zero performs no write, even if the register value on the operand port is not zero. Three addresses are implemented: a fully writable scratch register at 0x009, a configuration register at 0x00A of which only the low byte can be written, and a read-only identification register at 0xC40. Every other address reads as zero and ignores writes. The returned value is combinational in the issuing cycle. The register update lands on the clock edge that ends that cycle.

Top module: `csr_exec_unit`

## Requirements
- R1: An instruction is acted on only when `instr_valid` is high, bits [6:0] equal 7'b1110011 and funct3 bits [13:12] are not 2'b00. Any other word, including funct3 000 with that opcode, changes no register and yields `rd_valid`=0.
- R2: When no read is performed, `rd_valid` is 0 and `rd_data` is 0. When a read is performed, `rd_valid` is 1 and `rd_data` carries the register value.
- R3: Fields: address = bits [31:20], rs1 field = bits [19:15], funct3 = bits [14:12], rd = bits [11:7]. Bit 14 selects the immediate form, in which the operand is the rs1 field zero-extended to 32 bits. Otherwise the operand is `rs1_data`.
- R4: funct3 [13:12] = 01 writes the operand, 10 ORs the operand in, and 11 ANDs the register with the inverted operand. `rd_data` always returns the value held before the update (e.g. 0x00001100 cleared with 0x00000111 returns 0x00001100 and becomes 0x00001000).
- R5: Write forms (funct3 001 and 101) with rd = 0 perform no read (`rd_valid`=0) but still write.
- R6: Set and clear forms (funct3 010, 011, 110, 111) with rs1 field = 0 read the register but do not write it, whatever `rs1_data` holds.
- R7: `rd_data` reflects the register value in the issuing cycle. The new value is visible to an access in the next cycle.
- R8: Address 0x009 is a 32-bit read/write scratch register that resets to 0.
- R9: Address 0x00A resets to 0. Only its bits [7:0] are writable, and bits [31:8] always read 0.
- R10: Address 0xC40 always reads 0x5A5A0001 and ignores writes.
- R11: Any other address reads 0 (`rd_valid` still follows R2/R5) and a write to it alters no implemented register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Instruction word is present this cycle |
| instr | input | 32 | Instruction word |
| rs1_data | input | 32 | Value of the integer register named by the rs1 field |
| rd_valid | output | 1 | A CSR read was performed; write `rd_data` to rd |
| rd_data | output | 32 | Register value before the update |

## Verification
The bench goes after the suppression rules. It issues a set and a clear with a zero source field while driving a nonzero `rs1_data`, so that a design which looks at the operand value instead of the field would corrupt the scratch register and be caught on the read-back. Plain writes to x0 are checked for a dropped valid flag and for the write still landing. A design that merged the two suppression rules would either lose that write or return data. The bench also checks the masked configuration byte, the read-only identifier, unimplemented addresses that could alias onto implemented ones when decoded loosely, and funct3 000 under the system opcode, which a design decoding only bit 14 would wrongly treat as an access.

// File: rtl/csr_exec_pkg.sv
// Package: shared types and the implemented register table of the CSR unit.
// Assumes a 32-bit datapath and a 12-bit register address.
package csr_exec_pkg;

    localparam int XLEN      = 32;
    localparam int ADDR_W    = 12;
    localparam int REG_IDX_W = 5;
    localparam int NUM_CSR   = 3;

    localparam logic [6:0] OPC_SYSTEM = 7'b1110011;

    // Implemented registers; entry 0 is the scratch register.
    localparam logic [NUM_CSR-1:0][ADDR_W-1:0] CSR_ADDR  = {12'hC40, 12'h00A, 12'h009};
    localparam logic [NUM_CSR-1:0][XLEN-1:0]   CSR_WMASK = {32'h0000_0000, 32'h0000_00FF, 32'hFFFF_FFFF};
    localparam logic [NUM_CSR-1:0][XLEN-1:0]   CSR_RST   = {32'h5A5A_0001, 32'h0000_0000, 32'h0000_0000};

    typedef enum logic [1:0] {
        CSR_OP_NONE  = 2'b00,
        CSR_OP_WRITE = 2'b01,
        CSR_OP_SET   = 2'b10,
        CSR_OP_CLEAR = 2'b11
    } csr_op_e;

    typedef struct packed {
        logic                 is_csr;
        logic                 rd_en;
        logic                 wr_en;
        logic                 use_imm;
        csr_op_e              op;
        logic [ADDR_W-1:0]    addr;
        logic [REG_IDX_W-1:0] rs1_idx;
        logic [REG_IDX_W-1:0] rd_idx;
    } csr_req_t;

endpackage

// File: rtl/csr_decode.sv
// Module: csr_decode
// Splits an instruction word into CSR access fields. It decides whether the
// word is a CSR access and whether its read and write side effects take place.
// Assumes the caller gates the result with its own valid flag.
module csr_decode
    import csr_exec_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output csr_req_t        req
);

    logic [2:0] funct3;
    logic       is_write_form;

    assign funct3        = instr[14:12];
    assign is_write_form = (funct3[1:0] == 2'b01);

    // Field extraction and side-effect rules.
    always_comb begin
        req.is_csr  = (instr[6:0] == OPC_SYSTEM) && (funct3[1:0] != 2'b00);
        req.use_imm = funct3[2];
        req.op      = csr_op_e'(funct3[1:0]);
        req.addr    = instr[31:20];
        req.rs1_idx = instr[19:15];
        req.rd_idx  = instr[11:7];
        req.rd_en   = req.is_csr && !(is_write_form && (req.rd_idx == '0));
        req.wr_en   = req.is_csr && (is_write_form || (req.rs1_idx != '0));
    end

endmodule

// File: rtl/csr_alu.sv
// Module: csr_alu
// Computes the updated register value from the old value and the operand.
// Assumes the operation code is one of write, set or clear when used.
module csr_alu
    import csr_exec_pkg::*;
(
    input  csr_op_e              op,
    input  logic                 use_imm,
    input  logic [REG_IDX_W-1:0] imm,
    input  logic [XLEN-1:0]      rs1_data,
    input  logic [XLEN-1:0]      old_val,
    output logic [XLEN-1:0]      new_val
);

    logic [XLEN-1:0] operand;

    // Operand select: zero-extended immediate or register value.
    always_comb begin
        operand = use_imm ? {{(XLEN-REG_IDX_W){1'b0}}, imm} : rs1_data;
    end

    // Apply write, set or clear.
    always_comb begin
        unique case (op)
            CSR_OP_WRITE: new_val = operand;
            CSR_OP_SET:   new_val = old_val | operand;
            CSR_OP_CLEAR: new_val = old_val & ~operand;
            default:      new_val = old_val;
        endcase
    end

endmodule

// File: rtl/csr_bank.sv
// Module: csr_bank
// Holds the implemented registers. Each one has its own address, writable
// mask and reset value from the package table. Reads of unknown addresses
// return zero and writes to them are dropped. Assumes addresses are unique.
module csr_bank
    import csr_exec_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             addr,
    input  logic                          we,
    input  logic [XLEN-1:0]               wdata,
    output logic [XLEN-1:0]               rdata,
    output logic [NUM_CSR-1:0][XLEN-1:0]  regs
);

    logic [NUM_CSR-1:0] hit;

    for (genvar g = 0; g < NUM_CSR; g++) begin : g_csr
        assign hit[g] = (addr == CSR_ADDR[g]);

        if (CSR_WMASK[g] == '0) begin : g_ro
            // Read-only entry: constant value.
            assign regs[g] = CSR_RST[g];
        end else begin : g_rw
            logic [XLEN-1:0] val_q;
            // Masked register update on a matching write.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    val_q <= CSR_RST[g];
                end else if (we && hit[g]) begin
                    val_q <= (val_q & ~CSR_WMASK[g]) | (wdata & CSR_WMASK[g]);
                end
            end
            assign regs[g] = val_q;
        end
    end

    // Read mux: OR of the selected entries, zero on no match.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CSR; i++) begin
            if (hit[i]) rdata = rdata | regs[i];
        end
    end

endmodule

// File: rtl/csr_exec_unit.sv
// Module: csr_exec_unit (top)
// Executes one CSR instruction per cycle. The old value is returned
// combinationally and the update is committed on the clock edge.
// Assumes rs1_data is the already-read source register value.
module csr_exec_unit
    import csr_exec_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            instr_valid,
    input  logic [31:0]     instr,
    input  logic [31:0]     rs1_data,
    output logic            rd_valid,
    output logic [31:0]     rd_data
);

    csr_req_t                      req;
    logic [XLEN-1:0]               old_val;
    logic [XLEN-1:0]               new_val;
    logic                          bank_we;
    logic [NUM_CSR-1:0][XLEN-1:0]  csr_regs;

    csr_decode u_decode (
        .instr (instr),
        .req   (req)
    );

    csr_bank u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (req.addr),
        .we    (bank_we),
        .wdata (new_val),
        .rdata (old_val),
        .regs  (csr_regs)
    );

    csr_alu u_alu (
        .op       (req.op),
        .use_imm  (req.use_imm),
        .imm      (req.rs1_idx),
        .rs1_data (rs1_data),
        .old_val  (old_val),
        .new_val  (new_val)
    );

    // Qualify side effects with the valid flag.
    always_comb begin
        bank_we  = instr_valid && req.wr_en;
        rd_valid = instr_valid && req.rd_en;
        rd_data  = rd_valid ? old_val : '0;
    end

endmodule

// File: rtl/csr_exec_checker.sv
// Module: csr_exec_checker
// Property checks for csr_exec_unit, attached with bind below.
module csr_exec_checker
    import csr_exec_pkg::*;
(
    input logic                          clk,
    input logic                          rst_n,
    input logic                          instr_valid,
    input logic [31:0]                   instr,
    input logic [31:0]                   rs1_data,
    input logic                          rd_valid,
    input logic [31:0]                   rd_data,
    input logic                          bank_we,
    input logic [NUM_CSR-1:0][XLEN-1:0]  csr_regs
);

    // R1: a non-CSR word never reads or writes.
    a_r1_non_csr_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[6:0] != OPC_SYSTEM || instr[13:12] == 2'b00) |-> (!rd_valid && !bank_we));

    // R2: no read means zero data.
    a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == '0));

    // R5: plain write to x0 reads nothing but writes.
    a_r5_x0_write_only: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr[6:0] == OPC_SYSTEM && instr[13:12] == 2'b01 && instr[11:7] == 5'd0)
        |-> (!rd_valid && bank_we));

    // R6: set/clear with zero source field never writes.
    a_r6_zero_src_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[13] && instr[19:15] == 5'd0) |-> !bank_we);

    // R8: register-form write to the scratch address lands next cycle.
    a_r8_scratch_write: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr[6:0] == OPC_SYSTEM && instr[14:12] == 3'b001 && instr[31:20] == 12'h009)
        |=> (csr_regs[0] == $past(rs1_data)));

    // R9: upper bits of the configuration register stay zero.
    a_r9_cfg_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        csr_regs[1][31:8] == '0);

endmodule

bind csr_exec_unit csr_exec_checker u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr       (instr),
    .rs1_data    (rs1_data),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data),
    .bank_we     (bank_we),
    .csr_regs    (csr_regs)
);

// File: tb/csr_exec_unit_tb_top.sv
// Scoreboard bench for csr_exec_unit. The driver pushes the expected result
// of each issued cycle; the monitor pops and compares it in the same cycle.
module csr_exec_unit_tb_top;

    localparam time CLK_PERIOD = 10ns;

    typedef struct {
        logic        v;
        logic [31:0] d;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] rs1_data = '0;
    logic        rd_valid;
    logic [31:0] rd_data;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    // Bench-side model of the register contents.
    logic [31:0] m_scr = '0;
    logic [31:0] m_cfg = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    csr_exec_unit dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .instr       (instr),
        .rs1_data    (rs1_data),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data)
    );

    function automatic logic [31:0] model_rd(input logic [11:0] a);
        case (a)
            12'h009: return m_scr;
            12'h00A: return m_cfg;
            12'hC40: return 32'h5A5A_0001;
            default: return 32'h0;
        endcase
    endfunction

    // Drive one raw cycle and push the given expectation.
    task automatic drive(input logic v, input logic [31:0] w, input logic [31:0] r1,
                         input logic ev, input logic [31:0] ed, input string tag);
        exp_t e;
        @(negedge clk);
        instr_valid = v;
        instr       = w;
        rs1_data    = r1;
        e.v = ev; e.d = ed; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Issue a CSR instruction; expectation comes from the requirement rules.
    task automatic csr_op(input logic [2:0] f3, input logic [4:0] rd, input logic [4:0] rs1f,
                          input logic [11:0] a, input logic [31:0] r1, input string tag);
        logic        is_acc, rden, wen;
        logic [31:0] old, opnd, nv;
        is_acc = (f3[1:0] != 2'b00);
        rden   = is_acc && !(f3[1:0] == 2'b01 && rd == 5'd0);
        wen    = is_acc && (f3[1:0] == 2'b01 || rs1f != 5'd0);
        old    = model_rd(a);
        opnd   = f3[2] ? {27'd0, rs1f} : r1;
        case (f3[1:0])
            2'b01:   nv = opnd;
            2'b10:   nv = old | opnd;
            2'b11:   nv = old & ~opnd;
            default: nv = old;
        endcase
        drive(1'b1, {a, rs1f, f3, rd, 7'b1110011}, r1, rden, rden ? old : 32'h0, tag);
        if (wen) begin
            if (a == 12'h009) m_scr = nv;
            if (a == 12'h00A) m_cfg = {24'd0, nv[7:0]};
        end
    endtask

    task automatic rd_csr(input logic [11:0] a, input string tag);
        csr_op(3'b010, 5'd1, 5'd0, a, 32'hFFFF_FFFF, tag);
    endtask

    // Monitor: compare in each cycle, a quarter period after the driving edge.
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_checks++;
                if (rd_valid !== e.v || rd_data !== e.d) begin
                    n_fail++;
                    $display("FAIL %s: got valid=%0b data=%08h, expected valid=%0b data=%08h",
                             e.tag, rd_valid, rd_data, e.v, e.d);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_PERIOD*20000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2: idle cycle after reset
        drive(1'b0, 32'h0, 32'h0, 1'b0, 32'h0, "R2 idle");
        // R8 R9 R10: reset values
        rd_csr(12'h009, "R8 scratch reset");
        rd_csr(12'h00A, "R9 cfg reset");
        rd_csr(12'hC40, "R10 id value");
        // R4 R7: write, old value returned, new visible next cycle
        csr_op(3'b001, 5'd5, 5'd4, 12'h009, 32'h0000_0100, "R4 write returns old");
        csr_op(3'b010, 5'd5, 5'd4, 12'h009, 32'h0000_0001, "R7 set sees prior write");
        rd_csr(12'h009, "R4 set result");
        // R4: the clear example
        csr_op(3'b001, 5'd5, 5'd4, 12'h009, 32'h0000_1100, "R4 write 1100");
        csr_op(3'b011, 5'd5, 5'd4, 12'h009, 32'h0000_0111, "R4 clear returns old");
        rd_csr(12'h009, "R4 clear result 1000");
        // R3: immediate forms
        csr_op(3'b101, 5'd6, 5'd27, 12'h009, 32'hDEAD_BEEF, "R3 write imm");
        rd_csr(12'h009, "R3 imm value 1B");
        csr_op(3'b110, 5'd6, 5'd4, 12'h009, 32'hFFFF_FFFF, "R3 set imm");
        csr_op(3'b111, 5'd6, 5'd3, 12'h009, 32'hFFFF_FFFF, "R3 clear imm");
        rd_csr(12'h009, "R3 imm result");
        // R5: write form with rd x0
        csr_op(3'b001, 5'd0, 5'd7, 12'h009, 32'hCAFE_0001, "R5 x0 write no read");
        rd_csr(12'h009, "R5 write still landed");
        csr_op(3'b101, 5'd0, 5'd9, 12'h009, 32'h0, "R5 x0 imm write no read");
        rd_csr(12'h009, "R5 imm write landed");
        // R6: zero source field with nonzero operand value
        csr_op(3'b010, 5'd2, 5'd0, 12'h009, 32'hFFFF_0000, "R6 set x0 read");
        csr_op(3'b011, 5'd2, 5'd0, 12'h009, 32'hFFFF_FFFF, "R6 clear x0 read");
        csr_op(3'b111, 5'd2, 5'd0, 12'h009, 32'hFFFF_FFFF, "R6 clear imm0 read");
        rd_csr(12'h009, "R6 scratch unchanged");
        // R9: masked configuration byte
        csr_op(3'b001, 5'd2, 5'd1, 12'h00A, 32'hFFFF_FFFF, "R9 cfg write");
        rd_csr(12'h00A, "R9 cfg reads FF");
        csr_op(3'b011, 5'd2, 5'd1, 12'h00A, 32'h0000_000F, "R9 cfg clear");
        rd_csr(12'h00A, "R9 cfg F0");
        // R10: read-only identifier
        csr_op(3'b001, 5'd2, 5'd1, 12'hC40, 32'h0, "R10 id write attempt");
        rd_csr(12'hC40, "R10 id unchanged");
        // R11: unimplemented addresses, including near aliases
        csr_op(3'b001, 5'd2, 5'd1, 12'h809, 32'h1234_5678, "R11 unimpl read zero");
        csr_op(3'b001, 5'd2, 5'd1, 12'h019, 32'h1234_5678, "R11 unimpl alias");
        csr_op(3'b110, 5'd2, 5'd31, 12'h00B, 32'h0, "R11 unimpl set");
        rd_csr(12'h009, "R11 scratch untouched");
        rd_csr(12'h00A, "R11 cfg untouched");
        // R1: other opcode, funct3 000, and valid low
        drive(1'b1, {12'h009, 5'd1, 3'b001, 5'd2, 7'b0110011}, 32'hFFFF_FFFF, 1'b0, 32'h0, "R1 other opcode");
        drive(1'b1, {12'h009, 5'd1, 3'b000, 5'd2, 7'b1110011}, 32'hFFFF_FFFF, 1'b0, 32'h0, "R1 funct3 000");
        drive(1'b1, {12'h009, 5'd1, 3'b100, 5'd2, 7'b1110011}, 32'hFFFF_FFFF, 1'b0, 32'h0, "R1 funct3 100");
        drive(1'b0, {12'h009, 5'd1, 3'b001, 5'd2, 7'b1110011}, 32'hFFFF_FFFF, 1'b0, 32'h0, "R2 valid low");
        rd_csr(12'h009, "R1 scratch untouched");
        drive(1'b0, 32'h0, 32'h0, 1'b0, 32'h0, "R2 final idle");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule